// File: doc/BRIEF.md
# SPI NAND Bring-Up Sequencer

This block brings a serial NAND flash out of power-up on an SPI mode-0 link. One `start` pulse runs a fixed series of chip-select frames: a device reset, then repeated status polls until the busy bit clears, and then an identification read. From the identification bytes the block picks the array geometry. It then issues two protected feature writes. The first turns on the on-die ECC and the second removes every block lock. Each feature write is enclosed by a write-enable frame and a write-disable frame.

The block contains its own byte shifter. It drives the serial clock at the system clock divided by an even parameter, and it holds chip select high for a guaranteed gap between frames. Status polls are spaced by a programmable number of clocks. The number of polls is bounded, so a device that stays busy produces a timeout error and does not hang the sequence. When the sequence ends, whether it succeeded or failed, `done` pulses for one cycle. The error flags and the detected geometry then stay valid until the next start.

Top module: `nand_bringup_ctrl`

## Requirements
- R1: The serial link is mode 0: `sck` is low whenever `cs_n` is high. Each transfer is 8 bits, most significant bit first. `mosi` is stable at every rising `sck` edge, and `miso` is sampled on that edge.
- R2: The first frame after `start` is a single byte 0xFF.
- R3: A status poll is one frame of three bytes: 0x0F, 0xC0, and a read byte. Only bit 0 of the read byte means busy. Polls repeat while that bit is 1, and `cs_n` stays high for at least `2*CLK_DIV + POLL_GAP` clocks between consecutive polls.
- R4: If `POLL_LIMIT` polls in a row all read busy, `err_timeout` is raised, `done` pulses, and no further frame is sent.
- R5: After the first poll that reads idle, an identification frame of four bytes is sent: 0x9F, 0x00, and then the manufacturer and capacity bytes are read.
- R6: A manufacturer byte of 0xC2 with a capacity byte of 0x12 gives `blocks` = 1024 and `high_cap` = 0. Manufacturer 0xC2 with capacity 0x22 gives `blocks` = 2048 and `high_cap` = 1.
- R7: Any other pair of identification bytes raises `err_nodev`, leaves `blocks` at 0, pulses `done`, and sends no further frame.
- R8: After a good identification, ECC is enabled with three frames: 0x06, then 0x1F 0xB0 0x10, then 0x04.
- R9: After the ECC frames, blocks are unlocked with three frames: 0x06, then 0x1F 0xA0 0x00, then 0x04. This is the last frame of the sequence.
- R10: Between any two frames, `cs_n` stays high for at least `2*CLK_DIV` system clocks.
- R11: `done` is high for exactly one cycle per sequence. A new `start` clears the error flags and the geometry outputs. After reset, `cs_n` is 1, `sck` is 0, and all outputs are 0.
- R12: A `start` pulse while a sequence is running has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the bring-up sequence (accepted only when idle) |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| done | output | 1 | One-cycle pulse when the sequence ends |
| err_nodev | output | 1 | Identification bytes not recognised |
| err_timeout | output | 1 | Device stayed busy for POLL_LIMIT polls |
| blocks | output | BLK_W | Detected erase-block count |
| high_cap | output | 1 | Detected part uses plane-select addressing |

## Verification
A behavioural flash model answers the polls and the identification read. It is driven from a table of cases that combine the manufacturer and capacity bytes with different busy durations. The two valid capacity codes show that the geometry is decoded. A wrong capacity byte and a wrong manufacturer byte each show that the sequence stops after the identification frame. The busy counts are chosen to tell the cases apart. Zero means no repeat. A small count checks the spacing between polls. A count of one less than the limit must still succeed, and a count far above the limit must end in a timeout. The bench checks every frame for length and content. It also checks the chip-select gaps, that `sck` is quiet whenever `cs_n` is high, and that `done` pulses once.

// File: rtl/nand_bringup_pkg.sv
`timescale 1ns/1ps
package nand_bringup_pkg;
   // command codes understood by the flash
   localparam logic [7:0] OP_RESET = 8'hFF;
   localparam logic [7:0] OP_GETF  = 8'h0F;
   localparam logic [7:0] OP_SETF  = 8'h1F;
   localparam logic [7:0] OP_RDID  = 8'h9F;
   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   // feature addresses and values
   localparam logic [7:0] FA_STAT  = 8'hC0;
   localparam logic [7:0] FA_CFG   = 8'hB0;
   localparam logic [7:0] FA_LOCK  = 8'hA0;
   localparam logic [7:0] CFG_ECC  = 8'h10;
   localparam logic [7:0] LOCK_NONE = 8'h00;

   // frames of the sequence, in issue order
   typedef enum logic [3:0] {
      ST_RESET, ST_POLL, ST_ID,
      ST_WREN_A, ST_ECC, ST_WRDI_A,
      ST_WREN_B, ST_UNLK, ST_WRDI_B
   } step_e;

   localparam step_e ST_LAST = ST_WRDI_B;

   typedef enum logic [2:0] {S_IDLE, S_CSLO, S_BYTE, S_GAP, S_PWAIT} seq_e;
endpackage

// File: rtl/nand_spi_shifter.sv
`timescale 1ns/1ps
module nand_spi_shifter #(
   parameter int CLK_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       busy,
   output logic       byte_done,
   output logic [7:0] rx_byte
);
   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and at least 2");
   end

   logic       busy_r;
   logic       sck_r;
   logic       mosi_r;
   logic       done_r;
   logic [2:0] bits;
   logic [7:0] sh;
   logic [7:0] rx;
   logic       tick;

   if (HALF == 1) begin : g_nodiv
      assign tick = busy_r;
   end else begin : g_div
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     cnt <= '0;
         else if (!busy_r)               cnt <= '0;
         else if (cnt == CW'(HALF - 1))  cnt <= '0;
         else                            cnt <= cnt + 1'b1;
      end
      assign tick = busy_r && (cnt == CW'(HALF - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_r <= 1'b0;
         sck_r  <= 1'b0;
         mosi_r <= 1'b0;
         done_r <= 1'b0;
         bits   <= '0;
         sh     <= '0;
         rx     <= '0;
      end else begin
         done_r <= 1'b0;
         if (go && !busy_r) begin
            busy_r <= 1'b1;
            sh     <= tx_byte;
            mosi_r <= tx_byte[7];
            bits   <= '0;
            sck_r  <= 1'b0;
         end else if (tick) begin
            if (!sck_r) begin
               sck_r <= 1'b1;
               rx    <= {rx[6:0], miso};
            end else begin
               sck_r <= 1'b0;
               if (bits == 3'd7) begin
                  busy_r <= 1'b0;
                  done_r <= 1'b1;
               end else begin
                  bits   <= bits + 3'd1;
                  sh     <= {sh[6:0], 1'b0};
                  mosi_r <= sh[6];
               end
            end
         end
      end
   end

   assign sck       = sck_r;
   assign mosi      = mosi_r;
   assign busy      = busy_r;
   assign byte_done = done_r;
   assign rx_byte   = rx;

   // R1
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_r |-> !sck_r);
   // R1
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_r && !sck_r && tick) |=> $stable(mosi_r));
endmodule

// File: rtl/nand_frame_rom.sv
`timescale 1ns/1ps
module nand_frame_rom
   import nand_bringup_pkg::*;
(
   input  step_e      step,
   input  logic [1:0] bidx,
   output logic [7:0] tx_byte,
   output logic [2:0] flen
);
   always_comb begin
      tx_byte = 8'h00;
      flen    = 3'd1;
      unique case (step)
         ST_RESET: tx_byte = OP_RESET;
         ST_POLL: begin
            flen = 3'd3;
            if (bidx == 2'd0)      tx_byte = OP_GETF;
            else if (bidx == 2'd1) tx_byte = FA_STAT;
         end
         ST_ID: begin
            flen = 3'd4;
            if (bidx == 2'd0) tx_byte = OP_RDID;
         end
         ST_WREN_A, ST_WREN_B: tx_byte = OP_WREN;
         ST_WRDI_A, ST_WRDI_B: tx_byte = OP_WRDI;
         ST_ECC: begin
            flen = 3'd3;
            case (bidx)
               2'd0:    tx_byte = OP_SETF;
               2'd1:    tx_byte = FA_CFG;
               default: tx_byte = CFG_ECC;
            endcase
         end
         ST_UNLK: begin
            flen = 3'd3;
            case (bidx)
               2'd0:    tx_byte = OP_SETF;
               2'd1:    tx_byte = FA_LOCK;
               default: tx_byte = LOCK_NONE;
            endcase
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/nand_id_decode.sv
`timescale 1ns/1ps
module nand_id_decode #(
   parameter logic [7:0] MFR_CODE = 8'hC2,
   parameter logic [7:0] CAP_NORM = 8'h12,
   parameter logic [7:0] CAP_HIGH = 8'h22,
   parameter int         NBLK_NORM = 1024,
   parameter int         NBLK_HIGH = 2048,
   parameter int         BLK_W     = 12
) (
   input  logic [7:0]       mfr,
   input  logic [7:0]       cap,
   output logic             hit,
   output logic             hc,
   output logic [BLK_W-1:0] nblk
);
   if (NBLK_HIGH >= (1 << BLK_W) || NBLK_NORM >= (1 << BLK_W)) begin : g_bad_w
      $error("BLK_W too narrow for block counts");
   end

   always_comb begin
      hit  = 1'b0;
      hc   = 1'b0;
      nblk = '0;
      if (mfr == MFR_CODE) begin
         if (cap == CAP_NORM) begin
            hit  = 1'b1;
            nblk = BLK_W'(NBLK_NORM);
         end else if (cap == CAP_HIGH) begin
            hit  = 1'b1;
            hc   = 1'b1;
            nblk = BLK_W'(NBLK_HIGH);
         end
      end
   end
endmodule

// File: rtl/nand_bringup_ctrl.sv
`timescale 1ns/1ps
module nand_bringup_ctrl
   import nand_bringup_pkg::*;
#(
   parameter int CLK_DIV    = 4,
   parameter int POLL_GAP   = 64,
   parameter int POLL_LIMIT = 1000,
   parameter int NBLK_NORM  = 1024,
   parameter int NBLK_HIGH  = 2048,
   parameter int BLK_W      = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             miso,
   output logic             sck,
   output logic             cs_n,
   output logic             mosi,
   output logic             done,
   output logic             err_nodev,
   output logic             err_timeout,
   output logic [BLK_W-1:0] blocks,
   output logic             high_cap
);
   localparam int CS_GAP = 2 * CLK_DIV;
   localparam int GMAX   = (CS_GAP > POLL_GAP) ? CS_GAP : POLL_GAP;
   localparam int GCW    = $clog2(GMAX + 1);
   localparam int PCW    = $clog2(POLL_LIMIT + 1);

   if (POLL_LIMIT < 1 || POLL_GAP < 1) begin : g_bad_poll
      $error("POLL_LIMIT and POLL_GAP must be at least 1");
   end

   seq_e             state;
   step_e            step;
   logic [1:0]       bidx;
   logic             cs_n_r;
   logic [GCW-1:0]   gap_cnt;
   logic [PCW-1:0]   poll_cnt;
   logic [7:0]       rx2, rx3;
   logic             done_r, nodev_r, to_r, hc_r;
   logic [BLK_W-1:0] blocks_r;

   logic             go, sh_busy, byte_done;
   logic [7:0]       tx_byte, rx_byte;
   logic [2:0]       flen;
   logic             id_hit, id_hc;
   logic [BLK_W-1:0] id_blocks;

   assign go = (state == S_CSLO);

   nand_frame_rom u_rom (
      .step    (step),
      .bidx    (bidx),
      .tx_byte (tx_byte),
      .flen    (flen)
   );

   nand_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .tx_byte   (tx_byte),
      .miso      (miso),
      .sck       (sck),
      .mosi      (mosi),
      .busy      (sh_busy),
      .byte_done (byte_done),
      .rx_byte   (rx_byte)
   );

   nand_id_decode #(
      .NBLK_NORM (NBLK_NORM),
      .NBLK_HIGH (NBLK_HIGH),
      .BLK_W     (BLK_W)
   ) u_id (
      .mfr  (rx2),
      .cap  (rx3),
      .hit  (id_hit),
      .hc   (id_hc),
      .nblk (id_blocks)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         step     <= ST_RESET;
         bidx     <= '0;
         cs_n_r   <= 1'b1;
         gap_cnt  <= '0;
         poll_cnt <= '0;
         rx2      <= '0;
         rx3      <= '0;
         done_r   <= 1'b0;
         nodev_r  <= 1'b0;
         to_r     <= 1'b0;
         hc_r     <= 1'b0;
         blocks_r <= '0;
      end else begin
         done_r <= 1'b0;
         unique case (state)
            S_IDLE: if (start) begin
               nodev_r  <= 1'b0;
               to_r     <= 1'b0;
               hc_r     <= 1'b0;
               blocks_r <= '0;
               step     <= ST_RESET;
               poll_cnt <= '0;
               bidx     <= '0;
               cs_n_r   <= 1'b0;
               state    <= S_CSLO;
            end
            S_CSLO: state <= S_BYTE;
            S_BYTE: if (byte_done) begin
               if (bidx == 2'd2) rx2 <= rx_byte;
               if (bidx == 2'd3) rx3 <= rx_byte;
               if ({1'b0, bidx} == flen - 3'd1) begin
                  cs_n_r  <= 1'b1;
                  gap_cnt <= '0;
                  state   <= S_GAP;
               end else begin
                  bidx  <= bidx + 2'd1;
                  state <= S_CSLO;
               end
            end
            S_GAP: if (gap_cnt == GCW'(CS_GAP - 1)) begin
               gap_cnt <= '0;
               bidx    <= '0;
               if (step == ST_POLL && rx2[0]) begin
                  if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
                     to_r   <= 1'b1;
                     done_r <= 1'b1;
                     state  <= S_IDLE;
                  end else begin
                     poll_cnt <= poll_cnt + 1'b1;
                     state    <= S_PWAIT;
                  end
               end else if (step == ST_ID && !id_hit) begin
                  nodev_r <= 1'b1;
                  done_r  <= 1'b1;
                  state   <= S_IDLE;
               end else if (step == ST_LAST) begin
                  done_r <= 1'b1;
                  state  <= S_IDLE;
               end else begin
                  if (step == ST_ID) begin
                     blocks_r <= id_blocks;
                     hc_r     <= id_hc;
                  end
                  step   <= step_e'(step + 4'd1);
                  cs_n_r <= 1'b0;
                  state  <= S_CSLO;
               end
            end else begin
               gap_cnt <= gap_cnt + 1'b1;
            end
            S_PWAIT: if (gap_cnt == GCW'(POLL_GAP - 1)) begin
               gap_cnt <= '0;
               cs_n_r  <= 1'b0;
               state   <= S_CSLO;
            end else begin
               gap_cnt <= gap_cnt + 1'b1;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign cs_n        = cs_n_r;
   assign done        = done_r;
   assign err_nodev   = nodev_r;
   assign err_timeout = to_r;
   assign blocks      = blocks_r;
   assign high_cap    = hc_r;

   // checker state: chip-select high run length
   logic           cs_q, seen_frame;
   logic [GCW:0]   hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q       <= 1'b1;
         seen_frame <= 1'b0;
         hi_cnt     <= '0;
      end else begin
         cs_q <= cs_n_r;
         if (cs_n_r && !cs_q) seen_frame <= 1'b1;
         if (!cs_n_r)                 hi_cnt <= '0;
         else if (hi_cnt != '1)       hi_cnt <= hi_cnt + 1'b1;
      end
   end

   // R10
   cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_r && cs_q && seen_frame) |-> (hi_cnt >= (GCW+1)'(CS_GAP)));
   // R1
   cs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_busy |-> !cs_n_r);
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_r |=> !done_r);
   // R4
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nodev_r && to_r));
   // R6
   geom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_r && !nodev_r && !to_r) |->
         ((blocks_r == BLK_W'(NBLK_NORM) && !hc_r) ||
          (blocks_r == BLK_W'(NBLK_HIGH) && hc_r)));
   // R7
   nodev_geom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nodev_r |-> (blocks_r == '0 && !hc_r));
endmodule

// File: tb/nand_bringup_ctrl_bench.sv
`timescale 1ns/1ps
module nand_bringup_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_DIV    = 4;
   localparam int POLL_GAP   = 20;
   localparam int POLL_LIMIT = 8;
   localparam int CS_GAP     = 2 * CLK_DIV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic miso = 1'b0;
   logic sck, cs_n, mosi, done, err_nodev, err_timeout, high_cap;
   logic [11:0] blocks;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_bringup_ctrl #(
      .CLK_DIV(CLK_DIV), .POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)
   ) u_nand_bringup_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .miso(miso),
      .sck(sck), .cs_n(cs_n), .mosi(mosi), .done(done),
      .err_nodev(err_nodev), .err_timeout(err_timeout),
      .blocks(blocks), .high_cap(high_cap)
   );

   int checks = 0;
   int errors = 0;

   // ---------------- flash model ----------------
   logic [7:0] m_mfr = 8'hC2, m_cap = 8'h12;
   int         busy_left = 0;
   logic [7:0] fbytes [64][4];
   int         flen [64];
   int         nfr = 0;
   logic [7:0] m_in = 8'h00, m_op = 8'h00, m_out = 8'h00;
   int         m_bit = 0, m_byte = 0;
   logic       last_busy = 1'b0;
   logic       had_frame = 1'b0;

   function automatic logic [7:0] resp(input logic [7:0] op, input int idx);
      if (op == 8'h0F && idx == 2) return (busy_left > 0) ? 8'h03 : 8'h02;
      if (op == 8'h9F && idx == 2) return m_mfr;
      if (op == 8'h9F && idx == 3) return m_cap;
      return 8'h00;
   endfunction

   always @(negedge cs_n) begin
      m_bit = 0; m_byte = 0; m_out = 8'h00; miso = 1'b0;
   end
   always @(posedge sck) if (!cs_n) begin
      m_in = {m_in[6:0], mosi};
      m_bit++;
      if (m_bit == 8) begin
         m_bit = 0;
         if (nfr < 64 && m_byte < 4) fbytes[nfr][m_byte] = m_in;
         if (m_byte == 0) m_op = m_in;
         m_byte++;
         m_out = resp(m_op, m_byte);
      end
   end
   always @(negedge sck) if (!cs_n) miso = m_out[7 - m_bit];
   always @(posedge cs_n) if (rst_n) begin
      if (nfr < 64) flen[nfr] = m_byte;
      last_busy = (m_op == 8'h0F && busy_left > 0);
      if (m_op == 8'h0F && busy_left > 0) busy_left--;
      nfr++;
      had_frame = 1'b1;
   end

   // ---------------- monitors ----------------
   int hi_run = 0, min_gap = 1 << 20, min_pgap = 1 << 20, done_cnt = 0, sck_bad = 0;
   logic cs_prev = 1'b1;
   always @(posedge clk) begin
      if (done) done_cnt++;
      if (!cs_n && cs_prev && had_frame) begin
         if (hi_run < min_gap) min_gap = hi_run;
         if (last_busy && hi_run < min_pgap) min_pgap = hi_run;
      end
      hi_run  = cs_n ? hi_run + 1 : 0;
      cs_prev = cs_n;
   end
   always @(negedge clk) if (cs_n && sck) sck_bad++;

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_frame(input int idx, input int len, input logic [7:0] b0,
                            input logic [7:0] b1, input logic [7:0] b2, input string tag);
      check(flen[idx] == len, {tag, " length"}, flen[idx], len);
      if (flen[idx] == len) begin
         check(fbytes[idx][0] == b0, {tag, " byte0"}, fbytes[idx][0], b0);
         if (len >= 2) check(fbytes[idx][1] == b1, {tag, " byte1"}, fbytes[idx][1], b1);
         if (len == 3) check(fbytes[idx][2] == b2, {tag, " byte2"}, fbytes[idx][2], b2);
      end
   endtask

   task automatic begin_run(input logic [7:0] mfr, input logic [7:0] cap, input int busy);
      m_mfr = mfr; m_cap = cap; busy_left = busy;
      nfr = 0; had_frame = 1'b0; done_cnt = 0;
      min_gap = 1 << 20; min_pgap = 1 << 20; sck_bad = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_end(input int extra_start_at);
      int n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
         if (n == extra_start_at) start = 1'b1;
         else start = 1'b0;
      end
      start = 1'b0;
      if (n >= 20000) check(1'b0, "watchdog", n, 0);
      repeat (300) @(negedge clk);
   endtask

   // ---------------- vector table ----------------
   typedef struct packed {
      logic [7:0]  mfr;
      logic [7:0]  cap;
      logic [7:0]  busy;
      logic        nodev;
      logic        tmo;
      logic [11:0] blk;
      logic        hc;
      logic [7:0]  nframes;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{8'hC2, 8'h12, 8'd0,   1'b0, 1'b0, 12'd1024, 1'b0, 8'd9},
      '{8'hC2, 8'h22, 8'd2,   1'b0, 1'b0, 12'd2048, 1'b1, 8'd11},
      '{8'hC2, 8'h33, 8'd0,   1'b1, 1'b0, 12'd0,    1'b0, 8'd3},
      '{8'hC8, 8'h12, 8'd1,   1'b1, 1'b0, 12'd0,    1'b0, 8'd4},
      '{8'hC2, 8'h22, 8'd100, 1'b0, 1'b1, 12'd0,    1'b0, 8'd9},
      '{8'hC2, 8'h12, 8'd7,   1'b0, 1'b0, 12'd1024, 1'b0, 8'd16}
   };

   initial begin : watchdog
      #(CLK_PERIOD * 190000);
      check(1'b0, "watchdog global", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R11 reset state
      check(cs_n == 1'b1 && sck == 1'b0, "R11 reset cs_n/sck", {cs_n, sck}, 2'b10);
      check(done == 0 && err_nodev == 0 && err_timeout == 0, "R11 reset flags",
            {done, err_nodev, err_timeout}, 0);
      check(blocks == 0 && high_cap == 0, "R11 reset geometry", blocks, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      for (int v = 0; v < 6; v++) begin
         int npoll;
         int ok;
         begin_run(VEC[v].mfr, VEC[v].cap, int'(VEC[v].busy));
         wait_end(-1);
         ok = (!VEC[v].nodev && !VEC[v].tmo);
         npoll = VEC[v].tmo ? POLL_LIMIT : int'(VEC[v].busy) + 1;
         check(nfr == int'(VEC[v].nframes), $sformatf("R4 R7 R9 frame count v%0d", v),
               nfr, VEC[v].nframes);
         check(err_nodev == VEC[v].nodev, $sformatf("R7 err_nodev v%0d", v), err_nodev, VEC[v].nodev);
         check(err_timeout == VEC[v].tmo, $sformatf("R4 err_timeout v%0d", v), err_timeout, VEC[v].tmo);
         check(blocks == VEC[v].blk, $sformatf("R6 blocks v%0d", v), blocks, VEC[v].blk);
         check(high_cap == VEC[v].hc, $sformatf("R6 high_cap v%0d", v), high_cap, VEC[v].hc);
         check(done_cnt == 1, $sformatf("R11 done pulses v%0d", v), done_cnt, 1);
         check(sck_bad == 0, $sformatf("R1 sck idle v%0d", v), sck_bad, 0);
         check(min_gap >= CS_GAP, $sformatf("R10 cs gap v%0d", v), min_gap, CS_GAP);
         if (npoll > 1)
            check(min_pgap >= CS_GAP + POLL_GAP, $sformatf("R3 poll spacing v%0d", v),
                  min_pgap, CS_GAP + POLL_GAP);
         chk_frame(0, 1, 8'hFF, 8'h00, 8'h00, "R2 reset frame");
         for (int p = 1; p <= npoll && p < 64; p++)
            chk_frame(p, 3, 8'h0F, 8'hC0, 8'h00, "R3 poll frame");
         if (!VEC[v].tmo) begin
            check(flen[npoll + 1] == 4, "R5 id length", flen[npoll + 1], 4);
            check(fbytes[npoll + 1][0] == 8'h9F && fbytes[npoll + 1][1] == 8'h00,
                  "R5 id bytes", {fbytes[npoll + 1][0], fbytes[npoll + 1][1]}, 16'h9F00);
         end
         if (ok != 0) begin
            chk_frame(npoll + 2, 1, 8'h06, 8'h00, 8'h00, "R8 write enable");
            chk_frame(npoll + 3, 3, 8'h1F, 8'hB0, 8'h10, "R8 ecc set");
            chk_frame(npoll + 4, 1, 8'h04, 8'h00, 8'h00, "R8 write disable");
            chk_frame(npoll + 5, 1, 8'h06, 8'h00, 8'h00, "R9 write enable");
            chk_frame(npoll + 6, 3, 8'h1F, 8'hA0, 8'h00, "R9 unlock set");
            chk_frame(npoll + 7, 1, 8'h04, 8'h00, 8'h00, "R9 write disable");
         end
      end

      // R11: new start clears flags left by a failed run
      begin_run(8'h00, 8'h00, 0);
      wait_end(-1);
      check(err_nodev == 1'b1, "R7 nodev before restart", err_nodev, 1);
      begin_run(8'hC2, 8'h12, 0);
      @(negedge clk);
      check(err_nodev == 1'b0 && blocks == 0, "R11 start clears outputs",
            {err_nodev, blocks}, 0);
      wait_end(-1);
      check(blocks == 12'd1024, "R6 blocks after restart", blocks, 1024);

      // R12: start during a running sequence is ignored
      begin_run(8'hC2, 8'h22, 2);
      wait_end(300);
      check(nfr == 11, "R12 frame count with mid-run start", nfr, 11);
      check(done_cnt == 1, "R12 single done with mid-run start", done_cnt, 1);
      check(high_cap == 1'b1 && blocks == 12'd2048, "R12 geometry with mid-run start",
            blocks, 2048);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule